// File: doc/BRIEF.md
# Block-transfer micro-op sequencer

This block sits behind the decoder and expands one multi-register transfer instruction into the ordered micro-operations that later pipeline stages execute. The instruction is given as a 16-bit mask of the registers to move, a base register index, and five flags: load or store, base writeback, ascending or descending addresses, user-bank or exception-return form, and whether the condition is "always". The block emits one micro-op per cycle over a valid/ready handshake. It does not touch the register file or memory. It only decides which micro-ops there are, their order, their operands and their commit flags.

On loads, two listed registers are merged into one 64-bit paired micro-op whenever this is allowed. This roughly halves the length of the sequence. A program-counter load that would otherwise come before the base update is sent to a scratch register and moved into the program counter after the writeback. As a result, the control transfer is always the final micro-op.

Top module: `mseq_sequencer`

## Requirements
- R1: `in_ready` is high when the block is idle, or in the cycle that the micro-op marked last is handed off. While a sequence still has other micro-ops to hand off, `in_ready` is low. While `out_ready` is low, the presented micro-op holds steady.
- R2: An empty register mask gives exactly one micro-op: kind 0 (copy base), dst0 = 16 (scratch A), addr = base, offset 0, marked last.
- R3: When a load's mask contains the base register, the first micro-op is kind 0 (copy base to 16). Every later memory micro-op then uses addr = 16. In all other cases, memory micro-ops use addr = base.
- R4: On a load with two or more registers still pending, the two lowest pending indices form one kind-2 micro-op (dst0 = lower index, dst1 = higher index). The offset then moves by 8. Registers are consumed lowest index first, and the first offset is 0.
- R5: With the exception-return form active (user flag set and register 15 listed), a load with exactly two pending registers is not paired.
- R6: Unpaired loads (kind 1) and stores (kind 4) carry one register each and move the offset by 4. Offsets go up when the up flag is set and down otherwise.
- R7: With writeback and a non-empty mask, one kind-5 micro-op (dst0 = addr = base) follows all memory micro-ops. Its offset is +4·n when ascending and −4·n when descending.
- R8: A load with writeback that lists register 15 loads that value into 17 (scratch B). After the kind-5 micro-op, a final move is issued: kind 6, or kind 7 in the exception-return form, with dst0 = 15 and addr = 17. The move carries the control and indirect flags. It also carries the return flag when the base is 13.
- R9: With the user flag set and register 15 not listed, every load or store micro-op carries the user-bank flag. A single load of register 15 without writeback in the exception-return form is kind 7's load twin, kind 3.
- R10: A load of register 15 without writeback carries the control and indirect flags. It carries exactly one of the conditional and unconditional flags: unconditional when `in_always` is set.
- R11: Every micro-op except the final one of a sequence has delayed-commit set and last clear. The final one has last set and delayed-commit clear.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| in_regs | input | 16 | Mask of registers to transfer |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_wb | input | 1 | Update base after transfer |
| in_up | input | 1 | Ascending addresses |
| in_user | input | 1 | User-bank / exception-return form |
| in_always | input | 1 | Condition is always true |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 3 | 0 copy, 1 load, 2 pair load, 3 load-return, 4 store, 5 base adjust, 6 move, 7 move-return |
| out_dst0 | output | 5 | First destination (or stored register) |
| out_dst1 | output | 5 | Second destination of a pair, else 0 |
| out_addr | output | 5 | Address / source register |
| out_ofs | output | 8 | Signed byte offset |
| out_usr | output | 1 | Use user-mode register bank |
| out_last | output | 1 | Final micro-op of the instruction |
| out_dcommit | output | 1 | Delay commit until the sequence ends |
| out_ctrl | output | 1 | Changes control flow |
| out_indirect | output | 1 | Indirect control transfer |
| out_cond | output | 1 | Conditional control transfer |
| out_uncond | output | 1 | Unconditional control transfer |
| out_ret | output | 1 | Subroutine return |

## Verification
An instruction is taken on the clock edge where `in_valid` and `in_ready` are both high. Its first micro-op is valid right after that edge, with no register between the accepted fields and the output. Each later micro-op appears on the edge after the previous one was taken. The bench holds a behavioural queue of the expected micro-ops. At every falling edge it compares the queue head with the outputs, including the cycles in which a random low `out_ready` stalls the block. It then checks `in_ready` one time step after driving `out_ready`, because that port depends combinationally on the handshake.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    K_COPY   = 3'd0,
    K_LD     = 3'd1,
    K_LDP    = 3'd2,
    K_LDRET  = 3'd3,
    K_ST     = 3'd4,
    K_WB     = 3'd5,
    K_MOV    = 3'd6,
    K_MOVRET = 3'd7
  } uop_kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_COPY = 3'd1,
    S_MEM  = 3'd2,
    S_WB   = 3'd3,
    S_MOVE = 3'd4
  } seq_state_e;

endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mseq_pick.sv
// Lowest set bit of a mask, as a binary index (0 when empty).
module mseq_pick #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mseq_popcnt.sv
module mseq_popcnt #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] part [W+1];

  assign part[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_acc
    assign part[g+1] = part[g] + CW'(vec[g]);
  end
  assign cnt = part[W];
endmodule

// File: rtl/mseq_uop_build.sv
// Forms the micro-op for the current sequencer state.
module mseq_uop_build
  import mseq_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IW    = 4,
  parameter int IDX_W = 5,
  parameter int CNT_W = 5,
  parameter int OFS_W = 8
) (
  input  seq_state_e              state,
  input  logic [NREG-1:0]         regs_q,
  input  logic [CNT_W-1:0]        rem_q,
  input  logic [CNT_W-1:0]        n_q,
  input  logic [IDX_W-1:0]        base_q,
  input  logic                    load_q,
  input  logic                    wb_q,
  input  logic                    up_q,
  input  logic                    force_q,
  input  logic                    exc_q,
  input  logic                    pctmp_q,
  input  logic                    copy_q,
  input  logic                    always_q,
  input  logic signed [OFS_W-1:0] ofs_q,
  output uop_kind_e               kind,
  output logic [IDX_W-1:0]        dst0,
  output logic [IDX_W-1:0]        dst1,
  output logic [IDX_W-1:0]        addr,
  output logic signed [OFS_W-1:0] ofs,
  output logic                    usr,
  output logic                    last,
  output logic                    ctrl,
  output logic                    indirect,
  output logic                    cond,
  output logic                    uncond,
  output logic                    ret,
  output logic                    pair,
  output logic [NREG-1:0]         clr
);
  localparam logic [IDX_W-1:0] TMP0 = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] TMP1 = IDX_W'(NREG + 1);
  localparam logic [IDX_W-1:0] PCW  = IDX_W'(NREG - 1);
  localparam logic [IDX_W-1:0] SPW  = IDX_W'(NREG - 3);
  localparam logic [IW-1:0]    PCI  = IW'(NREG - 1);

  logic [IW-1:0]   i1, i2;
  logic [NREG-1:0] bit1, bit2, rest;
  logic [IDX_W-1:0] mem_addr;
  logic signed [OFS_W-1:0] wb_mag;

  mseq_pick #(.W(NREG), .IW(IW)) u_pick_a (.vec(regs_q), .idx(i1));
  assign bit1 = NREG'(1) << i1;
  assign rest = regs_q & ~bit1;
  mseq_pick #(.W(NREG), .IW(IW)) u_pick_b (.vec(rest), .idx(i2));
  assign bit2 = NREG'(1) << i2;

  assign pair = load_q && (rem_q >= CNT_W'(2)) &&
                !((rem_q == CNT_W'(2)) && regs_q[NREG-1] && exc_q);
  assign mem_addr = copy_q ? TMP0 : base_q;
  assign wb_mag   = OFS_W'({n_q, 2'b00});

  always_comb begin
    kind     = K_COPY;
    dst0     = '0;
    dst1     = '0;
    addr     = '0;
    ofs      = '0;
    usr      = 1'b0;
    last     = 1'b0;
    ctrl     = 1'b0;
    indirect = 1'b0;
    cond     = 1'b0;
    uncond   = 1'b0;
    ret      = 1'b0;
    clr      = '0;
    case (state)
      S_COPY: begin
        kind = K_COPY;
        dst0 = TMP0;
        addr = base_q;
        last = (n_q == '0);
      end
      S_MEM: begin
        addr = mem_addr;
        ofs  = ofs_q;
        usr  = force_q;
        if (pair) begin
          kind = K_LDP;
          dst0 = IDX_W'(i1);
          dst1 = (i2 == PCI && pctmp_q) ? TMP1 : IDX_W'(i2);
          clr  = bit1 | bit2;
          last = (rem_q == CNT_W'(2)) && !wb_q;
          if (!wb_q && i2 == PCI) begin
            ctrl = 1'b1; indirect = 1'b1;
            cond = !always_q; uncond = always_q;
          end
        end else begin
          clr  = bit1;
          last = (rem_q == CNT_W'(1)) && !wb_q;
          if (load_q) begin
            if (wb_q && i1 == PCI) begin
              kind = K_LD;
              dst0 = TMP1;
            end else if (i1 == PCI && exc_q) begin
              kind = K_LDRET;
              dst0 = IDX_W'(i1);
            end else begin
              kind = K_LD;
              dst0 = IDX_W'(i1);
            end
            if (!wb_q && i1 == PCI) begin
              ctrl = 1'b1; indirect = 1'b1;
              cond = !always_q; uncond = always_q;
            end
          end else begin
            kind = K_ST;
            dst0 = IDX_W'(i1);
          end
        end
      end
      S_WB: begin
        kind = K_WB;
        dst0 = base_q;
        addr = base_q;
        ofs  = up_q ? wb_mag : -wb_mag;
        last = !pctmp_q;
      end
      S_MOVE: begin
        kind     = exc_q ? K_MOVRET : K_MOV;
        dst0     = PCW;
        addr     = TMP1;
        last     = 1'b1;
        ctrl     = 1'b1;
        indirect = 1'b1;
        cond     = !always_q;
        uncond   = always_q;
        ret      = (base_q == SPW);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
  import mseq_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int OFS_W = 8,
  localparam int IW    = $clog2(NREG),
  localparam int IDX_W = IW + 1,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [NREG-1:0]         in_regs,
  input  logic [IW-1:0]           in_base,
  input  logic                    in_load,
  input  logic                    in_wb,
  input  logic                    in_up,
  input  logic                    in_user,
  input  logic                    in_always,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [2:0]              out_kind,
  output logic [IDX_W-1:0]        out_dst0,
  output logic [IDX_W-1:0]        out_dst1,
  output logic [IDX_W-1:0]        out_addr,
  output logic signed [OFS_W-1:0] out_ofs,
  output logic                    out_usr,
  output logic                    out_last,
  output logic                    out_dcommit,
  output logic                    out_ctrl,
  output logic                    out_indirect,
  output logic                    out_cond,
  output logic                    out_uncond,
  output logic                    out_ret
);
  logic rst_sync_n;
  mseq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  seq_state_e              state_q, state_d;
  logic [NREG-1:0]         regs_q, regs_d;
  logic [CNT_W-1:0]        rem_q, rem_d, n_q, n_d, in_cnt;
  logic [IDX_W-1:0]        base_q, base_d;
  logic                    load_q, load_d, wb_q, wb_d, up_q, up_d;
  logic                    force_q, force_d, exc_q, exc_d, pctmp_q, pctmp_d;
  logic                    copy_q, copy_d, always_q, always_d;
  logic signed [OFS_W-1:0] ofs_q, ofs_d, step;

  uop_kind_e       b_kind;
  logic            b_last, b_pair;
  logic [NREG-1:0] b_clr;
  logic            acc, hs, en, in_copy;

  mseq_popcnt #(.W(NREG), .CW(CNT_W)) u_cnt (.vec(in_regs), .cnt(in_cnt));

  mseq_uop_build #(
    .NREG(NREG), .IW(IW), .IDX_W(IDX_W), .CNT_W(CNT_W), .OFS_W(OFS_W)
  ) u_build (
    .state(state_q), .regs_q(regs_q), .rem_q(rem_q), .n_q(n_q),
    .base_q(base_q), .load_q(load_q), .wb_q(wb_q), .up_q(up_q),
    .force_q(force_q), .exc_q(exc_q), .pctmp_q(pctmp_q), .copy_q(copy_q),
    .always_q(always_q), .ofs_q(ofs_q),
    .kind(b_kind), .dst0(out_dst0), .dst1(out_dst1), .addr(out_addr),
    .ofs(out_ofs), .usr(out_usr), .last(b_last), .ctrl(out_ctrl),
    .indirect(out_indirect), .cond(out_cond), .uncond(out_uncond),
    .ret(out_ret), .pair(b_pair), .clr(b_clr)
  );

  assign out_valid   = (state_q != S_IDLE);
  assign out_kind    = b_kind;
  assign out_last    = b_last;
  assign out_dcommit = out_valid && !b_last;
  assign hs          = out_valid && out_ready;
  assign in_ready    = (state_q == S_IDLE) || (hs && b_last);
  assign acc         = in_valid && in_ready;
  assign en          = acc || hs;
  assign in_copy     = (in_load && in_regs[in_base]) || (in_cnt == '0);
  assign step        = b_pair ? OFS_W'(8) : OFS_W'(4);

  always_comb begin
    state_d  = state_q;  regs_d  = regs_q;  rem_d   = rem_q;   n_d   = n_q;
    base_d   = base_q;   load_d  = load_q;  wb_d    = wb_q;    up_d  = up_q;
    force_d  = force_q;  exc_d   = exc_q;   pctmp_d = pctmp_q; copy_d = copy_q;
    always_d = always_q; ofs_d   = ofs_q;
    if (hs) begin
      case (state_q)
        S_COPY: state_d = (n_q == '0) ? S_IDLE : S_MEM;
        S_MEM: begin
          regs_d = regs_q & ~b_clr;
          rem_d  = rem_q - (b_pair ? CNT_W'(2) : CNT_W'(1));
          ofs_d  = up_q ? (ofs_q + step) : (ofs_q - step);
          if (rem_d == '0) state_d = wb_q ? S_WB : S_IDLE;
        end
        S_WB:    state_d = pctmp_q ? S_MOVE : S_IDLE;
        S_MOVE:  state_d = S_IDLE;
        default: state_d = S_IDLE;
      endcase
    end
    if (acc) begin
      regs_d   = in_regs;
      rem_d    = in_cnt;
      n_d      = in_cnt;
      base_d   = IDX_W'(in_base);
      load_d   = in_load;
      wb_d     = in_wb;
      up_d     = in_up;
      force_d  = in_user && !in_regs[NREG-1];
      exc_d    = in_user && in_regs[NREG-1];
      pctmp_d  = in_load && in_wb && in_regs[NREG-1];
      copy_d   = in_copy;
      always_d = in_always;
      ofs_d    = '0;
      state_d  = in_copy ? S_COPY : S_MEM;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= S_IDLE;
      regs_q   <= '0;  rem_q  <= '0;  n_q     <= '0;  base_q <= '0;
      load_q   <= 1'b0; wb_q  <= 1'b0; up_q   <= 1'b0;
      force_q  <= 1'b0; exc_q <= 1'b0; pctmp_q <= 1'b0; copy_q <= 1'b0;
      always_q <= 1'b0; ofs_q <= '0;
    end else if (en) begin
      state_q  <= state_d;
      regs_q   <= regs_d;  rem_q  <= rem_d;  n_q     <= n_d;  base_q <= base_d;
      load_q   <= load_d;  wb_q   <= wb_d;   up_q    <= up_d;
      force_q  <= force_d; exc_q  <= exc_d;  pctmp_q <= pctmp_d; copy_q <= copy_d;
      always_q <= always_d; ofs_q <= ofs_d;
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
      $stable(out_dst0) && $stable(out_addr) && $stable(out_ofs)));

  // R1
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_ready) |-> (!out_valid || (out_ready && out_last)));

  // R1
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ready && out_last && !in_valid) |=> !out_valid);

  // R8
  move_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ready && out_kind == 3'd5 && !out_last) |=>
      (out_valid && (out_kind == 3'd6 || out_kind == 3'd7)));

  // R8
  ret_on_move_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ret) |-> (out_ctrl && (out_kind == 3'd6 || out_kind == 3'd7)));

  // R10
  ctrl_cond_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ctrl) |-> (out_indirect && $countones({out_cond, out_uncond}) == 1));
endmodule

// File: tb/mseq_sequencer_bench.sv
module mseq_sequencer_bench;
  typedef struct packed {
    logic [2:0] k;
    logic [4:0] d0, d1, a;
    logic [7:0] o;
    logic usr, last, dc, ctrl, ind, cnd, unc, ret;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_load = 1'b0, in_wb = 1'b0, in_up = 1'b0;
  logic in_user = 1'b0, in_always = 1'b0, out_ready = 1'b0;
  logic [15:0] in_regs = '0;
  logic [3:0]  in_base = '0;
  logic in_ready, out_valid, out_usr, out_last, out_dcommit, out_ctrl;
  logic out_indirect, out_cond, out_uncond, out_ret;
  logic [2:0] out_kind;
  logic [4:0] out_dst0, out_dst1, out_addr;
  logic signed [7:0] out_ofs;

  int checks = 0, errors = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  mseq_sequencer u_mseq_sequencer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_regs(in_regs), .in_base(in_base), .in_load(in_load), .in_wb(in_wb),
    .in_up(in_up), .in_user(in_user), .in_always(in_always),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst0(out_dst0), .out_dst1(out_dst1), .out_addr(out_addr),
    .out_ofs(out_ofs), .out_usr(out_usr), .out_last(out_last),
    .out_dcommit(out_dcommit), .out_ctrl(out_ctrl), .out_indirect(out_indirect),
    .out_cond(out_cond), .out_uncond(out_uncond), .out_ret(out_ret)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t mk(int k, int d0, int d1, int a, int o);
    exp_t e = '0;
    e.k = 3'(k); e.d0 = 5'(d0); e.d1 = 5'(d1); e.a = 5'(a); e.o = 8'(o);
    return e;
  endfunction

  // Behavioural expectation built from the requirement text.
  task automatic expect_seq(input logic [15:0] regs, input int base, input bit ld,
                            input bit wb, input bit up, input bit usr, input bit alw);
    int n = $countones(regs);
    bit cp = (ld && regs[base]) || n == 0;
    bit exc = usr && regs[15];
    bit frc = usr && !regs[15];
    bit pct = ld && wb && regs[15];
    int ar = cp ? 16 : base;
    int rem = n, ofs = 0;
    int list[$];
    exp_t e;
    q.delete();
    for (int i = 0; i < 16; i++) if (regs[i]) list.push_back(i);
    if (cp) q.push_back(mk(0, 16, 0, base, 0));
    while (rem > 0) begin
      if (ld && rem >= 2 && !(rem == 2 && regs[15] && exc)) begin
        int r1 = list.pop_front();
        int r2 = list.pop_front();
        e = mk(2, r1, (r2 == 15 && pct) ? 17 : r2, ar, ofs);
        if (!wb && r2 == 15) begin
          e.ctrl = 1; e.ind = 1; e.cnd = !alw; e.unc = alw;
        end
        e.usr = frc;
        q.push_back(e);
        ofs += up ? 8 : -8; rem -= 2;
      end else begin
        int r1 = list.pop_front();
        if (!ld) e = mk(4, r1, 0, ar, ofs);
        else if (wb && r1 == 15) e = mk(1, 17, 0, ar, ofs);
        else if (r1 == 15 && exc) e = mk(3, r1, 0, ar, ofs);
        else e = mk(1, r1, 0, ar, ofs);
        if (ld && !wb && r1 == 15) begin
          e.ctrl = 1; e.ind = 1; e.cnd = !alw; e.unc = alw;
        end
        e.usr = frc;
        q.push_back(e);
        ofs += up ? 4 : -4; rem -= 1;
      end
    end
    if (wb && n > 0) q.push_back(mk(5, base, 0, base, up ? 4 * n : -4 * n));
    if (pct) begin
      e = mk(exc ? 7 : 6, 15, 0, 17, 0);
      e.ctrl = 1; e.ind = 1; e.cnd = !alw; e.unc = alw; e.ret = (base == 13);
      q.push_back(e);
    end
    for (int i = 0; i < q.size(); i++) begin
      q[i].last = (i == q.size() - 1);
      q[i].dc   = (i != q.size() - 1);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] regs, input int base,
                     input bit ld, input bit wb, input bit up, input bit usr,
                     input bit alw);
    exp_t act;
    expect_seq(regs, base, ld, wb, up, usr, alw);
    @(negedge clk);
    in_regs = regs; in_base = 4'(base); in_load = ld; in_wb = wb; in_up = up;
    in_user = usr; in_always = alw; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    check(in_ready === 1'b1, {tag, "/R1 ready idle"}, 64'(in_ready), 64'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    while (q.size() > 0) begin
      @(negedge clk);
      act = {out_kind, out_dst0, out_dst1, out_addr, out_ofs, out_usr, out_last,
             out_dcommit, out_ctrl, out_indirect, out_cond, out_uncond, out_ret};
      check(out_valid === 1'b1, {tag, "/R1 valid"}, 64'(out_valid), 64'd1);
      check(act === q[0], {tag, "/R11 uop"}, 64'(act), 64'(q[0]));
      out_ready = ($urandom % 4) != 0;
      #1;
      check(in_ready === (out_ready && q.size() == 1), {tag, "/R1 ready busy"},
            64'(in_ready), 64'(out_ready && q.size() == 1));
      @(posedge clk);
      if (out_ready) void'(q.pop_front());
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0, {tag, "/R1 drained"}, 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(out_valid === 1'b0, "R12 valid", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R12 ready", 64'(in_ready), 64'd1);
    // R2 empty mask
    run("R2", 16'h0000, 5, 1, 1, 1, 0, 1);
    // R4 pairing ascending
    run("R4", 16'h000E, 0, 1, 0, 1, 0, 1);
    // R3 base in list, descending with writeback
    run("R3", 16'h00A5, 2, 1, 1, 0, 0, 1);
    // R6 R7 stores ascending with writeback
    run("R7", 16'h0211, 3, 0, 1, 1, 0, 1);
    // R6 store descending
    run("R6", 16'h0C00, 1, 0, 0, 0, 0, 0);
    // R8 pc with writeback, stack base
    run("R8", 16'h8010, 13, 1, 1, 1, 0, 1);
    // R5 R9 R10 exception return, two pending, conditional
    run("R5", 16'h8008, 4, 1, 0, 1, 1, 0);
    // R9 user bank without pc
    run("R9", 16'h0700, 0, 1, 0, 1, 1, 1);
    // R10 lone pc load, unconditional
    run("R10", 16'h8000, 2, 1, 0, 0, 0, 1);
    // R8 exception return with writeback, odd count
    run("R8x", 16'h8006, 13, 1, 1, 1, 1, 0);
    // R11 full store list
    run("R11", 16'hFFFF, 6, 0, 1, 0, 0, 1);
    // R4 pair ending in pc, no writeback
    run("R4pc", 16'h8001, 5, 1, 0, 1, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule